// File: doc/BRIEF.md
# Serial Peripheral Interrupt Register Block

This block keeps the interrupt bookkeeping for a serial peripheral that has four interrupt causes: transmit level reached, receive level reached, transmit drained and receive overrun. Single-cycle event pulses from the peripheral's datapath latch into a sticky pending register. Software sees and changes that register through a small 32-bit register port with word addressing.

Software can acknowledge pending causes by writing ones to the pending register. It can force causes by writing to a write-only injection register. It can choose which causes reach the outside through a mask register. Each cause drives its own level line, which is high while that cause is both pending and unmasked.

The register port takes one request per cycle. It returns read data one cycle after the request is accepted.

Top module: `ser_irq_block`

## Requirements
- R1: Cause `i` uses bit `i` of the event input, of the pending, mask and injection registers, and of the line output. The assignment is: bit 0 transmit level, bit 1 receive level, bit 2 transmit drained, bit 3 receive overrun. An event pulse on `hw_event[i]` sets pending bit `i`.
- R2: A write to word offset 0x0 (pending) clears each pending bit whose written data bit is 1. Pending bits written as 0 keep their value.
- R3: A write to word offset 0x8 (injection) ORs data bits 3:0 into the pending register.
- R4: `irq_line[i]` is high exactly when pending bit `i` and mask bit `i` are both 1. It follows any register update from the clock edge at which that update takes place.
- R5: A synchronous active-high `rst` clears pending and mask. All lines are then low, and reads of pending and mask return 0.
- R6: A read of offset 0x0 returns the pending bits in data bits 3:0, with data bits 31:4 at zero. The value returned is the one held before the edge that accepts the read.
- R7: A read of offset 0x8 always returns 0.
- R8: When an event pulse and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R9: A read of any word offset other than 0x0, 0x4 and 0x8 returns 0. A write to such an offset changes no register.
- R10: A write to word offset 0x4 (mask) replaces all four mask bits with data bits 3:0. A read of 0x4 returns them in bits 3:0, with zeros above.
- R11: `req_ready` is always high. `rsp_valid` is high in the cycle after each accepted read and low in the cycle after any cycle that accepts no read, including writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Byte address; bits 9:2 select the word |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| hw_event | input | 4 | Per-cause event pulses from the peripheral |
| irq_line | output | 4 | Per-cause interrupt levels |

## Verification
Pending and mask changes take effect at the edge that accepts the write or event. The lines are formed from these registers without a further register, so each line is due in the same cycle, just after that edge. Read data and `rsp_valid` come from one output register and are due one edge after the request. The bench applies each stimulus at a falling edge, waits for the next rising edge, and samples one nanosecond after it. Its reference model computes each read result from the register values held before that edge, and computes each line from the values after it.

// File: rtl/ser_irq_pkg.sv
`timescale 1ns/1ps
package ser_irq_pkg;

    localparam int unsigned IRQ_CAUSES  = 4;
    localparam int unsigned PORT_DATA_W = 32;
    localparam int unsigned PORT_ADDR_W = 10;

    // word indices of the three registers
    localparam int unsigned WORD_PENDING = 0;
    localparam int unsigned WORD_MASK    = 1;
    localparam int unsigned WORD_INJECT  = 2;

    typedef enum logic [1:0] {
        CAUSE_TX_LEVEL = 2'd0,
        CAUSE_RX_LEVEL = 2'd1,
        CAUSE_TX_DONE  = 2'd2,
        CAUSE_RX_OVRUN = 2'd3
    } cause_e;

    typedef enum logic [1:0] {
        SEL_PENDING = 2'd0,
        SEL_MASK    = 2'd1,
        SEL_INJECT  = 2'd2,
        SEL_NONE    = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     wr_pending;
        logic     wr_mask;
        logic     wr_inject;
        logic     rd_accept;
        reg_sel_e sel;
    } dec_t;

    function automatic reg_sel_e word_to_sel(input int unsigned word);
        case (word)
            WORD_PENDING: return SEL_PENDING;
            WORD_MASK:    return SEL_MASK;
            WORD_INJECT:  return SEL_INJECT;
            default:      return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/irq_reg_decode.sv
`timescale 1ns/1ps
module irq_reg_decode
    import ser_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = PORT_ADDR_W
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output dec_t              dec
);
    localparam int unsigned WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word_idx;
    logic [1:0]        unused_byte_sel;
    reg_sel_e          sel;

    assign word_idx        = req_addr[ADDR_W-1:2];
    assign unused_byte_sel = req_addr[1:0];

    always_comb begin
        sel = word_to_sel(int'(word_idx));
        dec = '0;
        dec.sel        = sel;
        dec.rd_accept  = req_valid && !req_write;
        dec.wr_pending = req_valid && req_write && (sel == SEL_PENDING);
        dec.wr_mask    = req_valid && req_write && (sel == SEL_MASK);
        dec.wr_inject  = req_valid && req_write && (sel == SEL_INJECT);
    end

endmodule

// File: rtl/irq_sticky_bank.sv
`timescale 1ns/1ps
module irq_sticky_bank #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] hw_set,
    input  logic [N-1:0] sw_clear,
    input  logic [N-1:0] sw_force,
    input  logic         mask_we,
    input  logic [N-1:0] mask_wdata,
    output logic [N-1:0] pending_q,
    output logic [N-1:0] mask_q
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic nxt;
        // any set source beats a clear in the same cycle
        always_comb begin
            nxt = pending_q[i];
            if (sw_clear[i])               nxt = 1'b0;
            if (hw_set[i] || sw_force[i])  nxt = 1'b1;
        end

        always_ff @(posedge clk) begin
            if (rst) pending_q[i] <= 1'b0;
            else     pending_q[i] <= nxt;
        end

        // R8
        set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
            hw_set[i] |=> pending_q[i]);

        // R2
        clear_takes_effect_chk: assert property (@(posedge clk) disable iff (rst)
            (sw_clear[i] && !hw_set[i] && !sw_force[i]) |=> !pending_q[i]);

        // R3
        force_sets_chk: assert property (@(posedge clk) disable iff (rst)
            sw_force[i] |=> pending_q[i]);

        // R2
        hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
            (!sw_clear[i] && !hw_set[i] && !sw_force[i]) |=> $stable(pending_q[i]));
    end

    always_ff @(posedge clk) begin
        if (rst)          mask_q <= '0;
        else if (mask_we) mask_q <= mask_wdata;
    end

    // R5
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (pending_q == '0 && mask_q == '0));

endmodule

// File: rtl/irq_line_gate.sv
`timescale 1ns/1ps
module irq_line_gate #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] pending,
    input  logic [N-1:0] mask,
    output logic [N-1:0] line
);

    for (genvar i = 0; i < N; i++) begin : g_line
        assign line[i] = pending[i] & mask[i];
    end

endmodule

// File: rtl/ser_irq_block.sv
`timescale 1ns/1ps
module ser_irq_block
    import ser_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = PORT_ADDR_W,
    parameter int unsigned DATA_W = PORT_DATA_W,
    parameter int unsigned N      = IRQ_CAUSES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic [N-1:0]      hw_event,
    output logic [N-1:0]      irq_line
);
    localparam int unsigned PAD_W = DATA_W - N;

    dec_t              dec;
    logic [N-1:0]      wr_bits;
    logic [N-1:0]      clr_bits;
    logic [N-1:0]      force_bits;
    logic [N-1:0]      pending_q;
    logic [N-1:0]      mask_q;
    logic [DATA_W-1:0] rd_next;
    logic [PAD_W-1:0]  unused_wdata_hi;

    assign req_ready       = 1'b1;
    assign wr_bits         = req_wdata[N-1:0];
    assign unused_wdata_hi = req_wdata[DATA_W-1:N];
    assign clr_bits        = dec.wr_pending ? wr_bits : '0;
    assign force_bits      = dec.wr_inject  ? wr_bits : '0;

    irq_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .dec       (dec)
    );

    irq_sticky_bank #(.N(N)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .hw_set     (hw_event),
        .sw_clear   (clr_bits),
        .sw_force   (force_bits),
        .mask_we    (dec.wr_mask),
        .mask_wdata (wr_bits),
        .pending_q  (pending_q),
        .mask_q     (mask_q)
    );

    irq_line_gate #(.N(N)) u_gate (
        .pending (pending_q),
        .mask    (mask_q),
        .line    (irq_line)
    );

    always_comb begin
        case (dec.sel)
            SEL_PENDING: rd_next = {{PAD_W{1'b0}}, pending_q};
            SEL_MASK:    rd_next = {{PAD_W{1'b0}}, mask_q};
            default:     rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= dec.rd_accept;
            if (dec.rd_accept) rsp_rdata <= rd_next;
        end
    end

    // R11
    read_answered_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rsp_valid);

    // R11
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req_write) |=> !rsp_valid);

    // R7
    inject_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (dec.rd_accept && dec.sel == SEL_INJECT) |=> (rsp_rdata == '0));

    // R9
    unmapped_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (dec.rd_accept && dec.sel == SEL_NONE) |=> (rsp_rdata == '0));

    // R6
    upper_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_rdata[DATA_W-1:N] == '0));

    for (genvar i = 0; i < N; i++) begin : g_line_chk
        // R4
        masked_off_chk: assert property (@(posedge clk) disable iff (rst)
            (dec.wr_mask && !wr_bits[i]) |=> !irq_line[i]);

        // R4
        event_unmasked_chk: assert property (@(posedge clk) disable iff (rst)
            (hw_event[i] && mask_q[i] && !dec.wr_mask) |=> irq_line[i]);
    end

endmodule

// File: tb/ser_irq_block_test.sv
`timescale 1ns/1ps
module ser_irq_block_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic        req_write;
    logic [9:0]  req_addr;
    logic [31:0] req_wdata;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [3:0]  hw_event;
    logic [3:0]  irq_line;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [3:0] m_pend;
    logic [3:0] m_mask;

    always #2.5 clk = ~clk;

    ser_irq_block uut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .hw_event  (hw_event),
        .irq_line  (irq_line)
    );

    // {write, read, addr[9:0], wdata[31:0], event[3:0]}
    localparam int NV = 18;
    localparam logic [47:0] VECS [NV] = '{
        {1'b0, 1'b1, 10'h000, 32'h0000_0000, 4'h0}, // R5 pending reads 0
        {1'b0, 1'b1, 10'h004, 32'h0000_0000, 4'h0}, // R5 mask reads 0
        {1'b1, 1'b0, 10'h004, 32'h0000_000F, 4'h0}, // R10 unmask all
        {1'b0, 1'b0, 10'h000, 32'h0000_0000, 4'h1}, // R1 tx level event
        {1'b0, 1'b0, 10'h000, 32'h0000_0000, 4'h4}, // R1 tx drained event
        {1'b0, 1'b1, 10'h000, 32'h0000_0000, 4'h0}, // R6 read pending
        {1'b1, 1'b0, 10'h000, 32'h0000_0001, 4'h0}, // R2 clear bit 0
        {1'b1, 1'b0, 10'h008, 32'h0000_000A, 4'h0}, // R3 inject bits 1,3
        {1'b0, 1'b1, 10'h008, 32'h0000_0000, 4'h0}, // R7 inject reads 0
        {1'b1, 1'b0, 10'h000, 32'h0000_0008, 4'h8}, // R8 set beats clear
        {1'b1, 1'b0, 10'h004, 32'h0000_0003, 4'h0}, // R4 mask change
        {1'b1, 1'b0, 10'h00C, 32'h0000_000F, 4'h0}, // R9 unmapped write
        {1'b0, 1'b1, 10'h00C, 32'h0000_0000, 4'h0}, // R9 unmapped read
        {1'b0, 1'b1, 10'h004, 32'h0000_0000, 4'h0}, // R10 mask readback
        {1'b1, 1'b0, 10'h000, 32'hFFFF_FFFF, 4'h0}, // R2 clear all
        {1'b1, 1'b0, 10'h008, 32'hFFFF_FFF0, 4'h2}, // R3 upper bits no effect, R1 rx level
        {1'b0, 1'b1, 10'h000, 32'h0000_0000, 4'h0}, // R6 upper bits zero
        {1'b0, 1'b1, 10'h3FC, 32'h0000_0000, 4'h0}  // R9 top of window
    };

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // apply one cycle at a falling edge, model it, check just after the rising edge
    task automatic step(input bit wr, input bit rd, input logic [9:0] addr,
                        input logic [31:0] wd, input logic [3:0] ev, input string req);
        logic [31:0] exp_rd;
        logic [3:0]  clr;
        logic [3:0]  frc;
        req_valid = wr | rd;
        req_write = wr;
        req_addr  = addr;
        req_wdata = wd;
        hw_event  = ev;
        case (addr[9:2])
            8'd0:    exp_rd = {28'h0, m_pend};
            8'd1:    exp_rd = {28'h0, m_mask};
            default: exp_rd = 32'h0;
        endcase
        clr = (wr && addr[9:2] == 8'd0) ? wd[3:0] : 4'h0;
        frc = (wr && addr[9:2] == 8'd2) ? wd[3:0] : 4'h0;
        @(posedge clk);
        m_pend = (m_pend & ~clr) | frc | ev;
        if (wr && addr[9:2] == 8'd1) m_mask = wd[3:0];
        #1;
        check(irq_line == (m_pend & m_mask), {req, " R4 lines"},
              {28'h0, irq_line}, {28'h0, m_pend & m_mask});
        check(rsp_valid == rd, {req, " R11 rsp_valid"}, {31'h0, rsp_valid}, {31'h0, rd});
        check(req_ready == 1'b1, {req, " R11 ready"}, {31'h0, req_ready}, 32'h1);
        if (rd) check(rsp_rdata == exp_rd, {req, " read data"}, rsp_rdata, exp_rd);
        @(negedge clk);
        req_valid = 1'b0;
        hw_event  = 4'h0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0;
        req_addr = '0; req_wdata = '0; hw_event = '0;
        m_pend = '0; m_mask = '0;
        repeat (3) @(negedge clk);
        // R5 lines low under reset
        check(irq_line == 4'h0, "R5 lines at reset", {28'h0, irq_line}, 32'h0);
        check(rsp_valid == 1'b0, "R5 no response at reset", {31'h0, rsp_valid}, 32'h0);
        rst = 1'b0;

        for (int k = 0; k < NV; k++) begin
            step(VECS[k][47], VECS[k][46], VECS[k][45:36], VECS[k][35:4],
                 VECS[k][3:0], $sformatf("vec%0d", k));
        end

        // R8 every bit: events and full clear together
        step(1'b1, 1'b0, 10'h004, 32'hF, 4'h0, "R10 unmask");
        step(1'b1, 1'b0, 10'h000, 32'hF, 4'hF, "R8 all bits");
        // R2 partial clear leaves others
        step(1'b1, 1'b0, 10'h000, 32'h5, 4'h0, "R2 partial");
        step(1'b0, 1'b1, 10'h000, 32'h0, 4'h0, "R2 readback");
        // R1 receive overrun alone
        step(1'b1, 1'b0, 10'h000, 32'hF, 4'h0, "R2 clear");
        step(1'b0, 1'b0, 10'h000, 32'h0, 4'h8, "R1 overrun");
        // R6 read in the same cycle as an event returns the old value
        step(1'b0, 1'b1, 10'h000, 32'h0, 4'h1, "R6 old value");
        step(1'b0, 1'b1, 10'h000, 32'h0, 4'h0, "R6 new value");

        // R5 reset after activity
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); #1;
        check(irq_line == 4'h0, "R5 lines after reset", {28'h0, irq_line}, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        m_pend = '0; m_mask = '0;
        step(1'b0, 1'b1, 10'h000, 32'h0, 4'h0, "R5 pending after reset");
        step(1'b0, 1'b1, 10'h004, 32'h0, 4'h0, "R5 mask after reset");
        step(1'b0, 1'b0, 10'h000, 32'h0, 4'h2, "R4 masked event");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule